// File: doc/BRIEF.md
# Burst Transmit Serial Interface

This block sits between a host that supplies a serial transmit bit stream and a symbol modulator. From the master clock it derives a bit clock for the host. The host changes its data on the rising edge of that clock, and the block samples the data on the falling edge. It pairs consecutive bits into two-bit symbols and presents each symbol with a one-cycle valid pulse.

A burst-enable input frames each transmission. A burst opens at the first falling bit-clock edge that sees burst-enable high. When burst-enable is low at the end of a symbol, the block runs on for a fixed tail of bits and then closes the burst. A separate burst-out flag repeats burst-enable after a fixed pipeline latency, so that downstream amplifiers can be switched in step with the modulated waveform.

A power input controls the transmit path. When it is low, the path sleeps. When it rises, a fixed-length calibration interval runs, flagged as busy, and the path then returns to service.

Top module: `txsym_burst_if`

## Requirements
- R1: A synchronous active-high reset puts the block in sleep, with bit_clk, sym_valid, sym_data, burst_out and busy all low.
- R2: While the path is ready, bit_clk has a period of CLK_DIV master cycles and is low for the first half of each period, counting from the cycle in which the path became ready. It rises after CLK_DIV/2 edges and falls at the edge CLK_DIV edges after ready began. In every other state it stays low.
- R3: tx_data is sampled at the master edge on which bit_clk falls. Two successive samples form one symbol, with the earlier bit in sym_data[1] and the later bit in sym_data[0]. sym_valid is high for exactly the one cycle that follows the edge completing the symbol.
- R4: A burst opens at the first falling bit_clk edge that samples burst_en high. The bit sampled at that edge is the first bit of the first symbol.
- R5: If burst_en is low at the edge that completes a symbol, exactly TAIL_BITS/2 further symbols (8 bits at the default) are issued and the burst then closes. burst_en is ignored during this tail.
- R6: Outside a burst, sym_valid stays low.
- R7: burst_out equals (burst_en AND pwr_on AND ready), sampled at one edge, seen after the PIPE_LAT-th edge counting that one.
- R8: With pwr_on low at an edge, the block is in sleep after that edge: any burst is abandoned, bit_clk is low, no symbol is issued and busy is low.
- R9: An edge that samples pwr_on high while the block sleeps starts calibration. busy is then high for exactly CAL_CYCLES cycles, with bit_clk low throughout, and the path is ready after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Transmit power request; low means sleep |
| burst_en | input | 1 | Burst enable from host |
| tx_data | input | 1 | Serial transmit data from host |
| bit_clk | output | 1 | Generated transmit bit clock |
| sym_data | output | 2 | Dibit symbol, first bit in the MSB |
| sym_valid | output | 1 | One-cycle strobe for sym_data |
| burst_out | output | 1 | Burst enable delayed by the pipeline latency |
| busy | output | 1 | High during calibration |

## Verification
All outputs are registered, so every result appears one master edge after the input that causes it. A symbol shows up in the cycle after the falling bit-clock edge that completes it, and burst_out follows PIPE_LAT edges after its input sample. busy rises one edge after pwr_on is seen high in sleep and lasts CAL_CYCLES cycles. The bench updates a reference model at each rising edge from the inputs it drove half a cycle earlier. At the next falling edge it compares the model with the outputs, so each result is checked in exactly the cycle it is due.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    PS_SLEEP = 2'd0,
    PS_CAL   = 2'd1,
    PS_READY = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/txb_pwr_ctrl.sv
module txb_pwr_ctrl
  import txb_pkg::*;
#(
  parameter int CAL_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  output logic run,
  output logic busy
);
  localparam int CCW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CCW-1:0] CAL_LAST = CCW'(CAL_CYCLES - 1);

  pwr_state_t state;
  logic [CCW-1:0] cal_cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_on) begin
      state   <= PS_SLEEP;
      cal_cnt <= '0;
    end else begin
      case (state)
        PS_SLEEP: begin
          state   <= PS_CAL;
          cal_cnt <= '0;
        end
        PS_CAL: begin
          if (cal_cnt == CAL_LAST) state <= PS_READY;
          else cal_cnt <= cal_cnt + 1'b1;
        end
        default: state <= PS_READY;
      endcase
    end
  end

  assign run  = (state == PS_READY);
  assign busy = (state == PS_CAL);

  assert_sleep_on_low_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (state == PS_SLEEP));
  assert_wake_to_cal_R9: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SLEEP && pwr_on) |=> busy);
endmodule

// File: rtl/txb_bitclk.sv
module txb_bitclk #(
  parameter int CLK_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bit_clk,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST     = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF_M1  = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      bit_clk <= 1'b0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == HALF_M1) bit_clk <= 1'b1;
      if (cnt == LAST)    bit_clk <= 1'b0;
    end
  end

  assign fall_stb = run && (cnt == LAST);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !bit_clk);
  assert_fall_from_high_R2: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> bit_clk);
endmodule

// File: rtl/txb_dibit.sv
module txb_dibit #(
  parameter int TAIL_BITS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       fall_stb,
  input  logic       tx_data,
  input  logic       burst_en,
  output logic [1:0] sym_data,
  output logic       sym_valid
);
  localparam int TAIL_SYMS = TAIL_BITS / 2;
  localparam int TW = $clog2(TAIL_SYMS + 1);
  localparam logic [TW-1:0] TAIL_INIT = TW'(TAIL_SYMS);

  logic          in_burst;
  logic          half_done;
  logic          first_bit;
  logic          tailing;
  logic [TW-1:0] tail_left;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      in_burst  <= 1'b0;
      half_done <= 1'b0;
      first_bit <= 1'b0;
      tailing   <= 1'b0;
      tail_left <= '0;
      sym_data  <= 2'b00;
      sym_valid <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      if (fall_stb) begin
        if (!in_burst) begin
          if (burst_en) begin
            in_burst  <= 1'b1;
            first_bit <= tx_data;
            half_done <= 1'b1;
          end
        end else if (!half_done) begin
          first_bit <= tx_data;
          half_done <= 1'b1;
        end else begin
          sym_data  <= {first_bit, tx_data};
          sym_valid <= 1'b1;
          half_done <= 1'b0;
          if (tailing) begin
            if (tail_left == TW'(1)) begin
              in_burst <= 1'b0;
              tailing  <= 1'b0;
              tail_left <= '0;
            end else begin
              tail_left <= tail_left - 1'b1;
            end
          end else if (!burst_en) begin
            tailing   <= 1'b1;
            tail_left <= TAIL_INIT;
          end
        end
      end
    end
  end

  assert_tail_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    tailing |-> (in_burst && tail_left != '0 && tail_left <= TAIL_INIT));
  assert_no_sym_outside_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_burst && !sym_valid) |=> !sym_valid || $past(fall_stb));
endmodule

// File: rtl/txb_delay_line.sv
module txb_delay_line #(
  parameter int DEPTH = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 1) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], din};
      end
      assign dout = sr[DEPTH-1];
      assert_first_stage_R7: assert property (@(posedge clk) disable iff (rst)
        sr[0] == $past(din) || $past(rst));
    end
  endgenerate
endmodule

// File: rtl/txsym_burst_if.sv
module txsym_burst_if #(
  parameter int CLK_DIV    = 64,
  parameter int TAIL_BITS  = 8,
  parameter int PIPE_LAT   = 160,
  parameter int CAL_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_on,
  input  logic       burst_en,
  input  logic       tx_data,
  output logic       bit_clk,
  output logic [1:0] sym_data,
  output logic       sym_valid,
  output logic       burst_out,
  output logic       busy
);
  logic run;
  logic run_eff;
  logic fall_stb;

  txb_pwr_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_pwr (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .run(run), .busy(busy)
  );

  assign run_eff = run && pwr_on;

  txb_bitclk #(.CLK_DIV(CLK_DIV)) u_bclk (
    .clk(clk), .rst(rst), .run(run_eff), .bit_clk(bit_clk), .fall_stb(fall_stb)
  );

  txb_dibit #(.TAIL_BITS(TAIL_BITS)) u_dibit (
    .clk(clk), .rst(rst), .run(run_eff), .fall_stb(fall_stb),
    .tx_data(tx_data), .burst_en(burst_en),
    .sym_data(sym_data), .sym_valid(sym_valid)
  );

  txb_delay_line #(.DEPTH(PIPE_LAT)) u_dly (
    .clk(clk), .rst(rst), .din(burst_en && run_eff), .dout(burst_out)
  );

  assert_valid_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> $fell(bit_clk));
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!bit_clk && !sym_valid));
endmodule

// File: tb/txsym_burst_if_bench.sv
module txsym_burst_if_bench;
  localparam int CLK_DIV    = 64;
  localparam int HALF       = CLK_DIV / 2;
  localparam int TAIL_SYMS  = 4;
  localparam int PIPE_LAT   = 160;
  localparam int CAL_CYCLES = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_on = 1'b0;
  logic burst_en = 1'b0;
  logic tx_data = 1'b0;
  logic bit_clk, sym_valid, burst_out, busy;
  logic [1:0] sym_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 1'b0;

  always #4 clk = ~clk;

  txsym_burst_if u_txsym_burst_if (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .burst_en(burst_en), .tx_data(tx_data),
    .bit_clk(bit_clk), .sym_data(sym_data), .sym_valid(sym_valid),
    .burst_out(burst_out), .busy(busy)
  );

  // reference model, states: 0 sleep, 1 calibrate, 2 ready
  int m_st, m_calc, m_pos, m_left, n_edge;
  bit m_inb, m_ph, m_first, m_tail, m_sv, m_bout;
  logic [1:0] m_sd;
  bit hist [PIPE_LAT];

  function automatic bit exp_bclk(int st, int pos);
    return (st == 2) && (pos >= HALF);
  endfunction

  always @(posedge clk) begin
    bit din, fall;
    cycles++;
    if (rst) begin
      m_st = 0; m_calc = 0; m_pos = 0; m_left = 0; n_edge = 0;
      m_inb = 0; m_ph = 0; m_first = 0; m_tail = 0; m_sv = 0; m_bout = 0; m_sd = 2'b00;
      for (int i = 0; i < PIPE_LAT; i++) hist[i] = 1'b0;
    end else begin
      din = burst_en && pwr_on && (m_st == 2);
      hist[n_edge % PIPE_LAT] = din;
      m_bout = hist[(n_edge + 1) % PIPE_LAT];
      n_edge++;
      fall = (m_st == 2) && (m_pos == CLK_DIV - 1);
      m_sv = 0;
      if (!pwr_on) begin
        m_st = 0; m_pos = 0; m_inb = 0; m_ph = 0; m_tail = 0; m_left = 0; m_sd = 2'b00;
      end else begin
        case (m_st)
          0: begin m_st = 1; m_calc = 0; end
          1: if (m_calc == CAL_CYCLES - 1) begin m_st = 2; m_pos = 0; end
             else m_calc++;
          default: begin
            m_pos = (m_pos + 1) % CLK_DIV;
            if (fall) begin
              if (!m_inb) begin
                if (burst_en) begin m_inb = 1; m_first = tx_data; m_ph = 1; end
              end else if (!m_ph) begin
                m_first = tx_data; m_ph = 1;
              end else begin
                m_sd = {m_first, tx_data}; m_sv = 1; m_ph = 0;
                if (m_tail) begin
                  m_left--;
                  if (m_left == 0) begin m_inb = 0; m_tail = 0; end
                end else if (!burst_en) begin
                  m_tail = 1; m_left = TAIL_SYMS;
                end
              end
            end
          end
        endcase
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // compare at the falling edge, then the host updates data on a rising bit clock
  logic prev_bclk = 1'b0;
  always @(negedge clk) begin
    if (started) begin
      check(m_st == 0 ? "R8" : "R2", "bit_clk", bit_clk, exp_bclk(m_st, m_pos));
      check(m_st == 0 ? "R8" : "R9", "busy", busy, m_st == 1);
      check(m_st == 0 ? "R8" : (m_tail ? "R5" : (m_sv ? "R4" : "R6")), "sym_valid", sym_valid, m_sv);
      if (m_sv) check("R3", "sym_data", sym_data, m_sd);
      check("R7", "burst_out", burst_out, m_bout);
    end
    if (bit_clk && !prev_bclk) tx_data <= 1'($urandom % 2);
    prev_bclk <= bit_clk;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(4);
    // R1: outputs after reset
    check("R1", "bit_clk reset", bit_clk, 0);
    check("R1", "sym_valid reset", sym_valid, 0);
    check("R1", "sym_data reset", sym_data, 0);
    check("R1", "burst_out reset", burst_out, 0);
    check("R1", "busy reset", busy, 0);
    rst = 1'b0;
    started = 1'b1;
    // R9: wake and calibrate
    pwr_on = 1'b1;
    wait_cyc(CAL_CYCLES + 20);
    // R4/R5: burst with drop in the middle of a symbol
    burst_en = 1'b1; wait_cyc(CLK_DIV * 20 + 37);
    burst_en = 1'b0; wait_cyc(CLK_DIV * 14);
    // R5: burst_en raised during tail is ignored, then a new burst follows
    burst_en = 1'b1; wait_cyc(CLK_DIV * 6 + 5);
    burst_en = 1'b0; wait_cyc(CLK_DIV * 3);
    burst_en = 1'b1; wait_cyc(CLK_DIV * 8);
    burst_en = 1'b0; wait_cyc(CLK_DIV * 12);
    // short pulse on burst_en
    burst_en = 1'b1; wait_cyc(3); burst_en = 1'b0; wait_cyc(CLK_DIV * 12);
    // R8: power drop mid burst
    burst_en = 1'b1; wait_cyc(CLK_DIV * 7 + 11);
    pwr_on = 1'b0; wait_cyc(60);
    pwr_on = 1'b1; wait_cyc(CAL_CYCLES + CLK_DIV * 6);
    burst_en = 1'b0; wait_cyc(CLK_DIV * 12);
    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      int sel = int'($urandom % 10);
      if (sel < 5) begin
        burst_en = 1'b1; wait_cyc(1 + int'($urandom % 2500));
      end else if (sel < 9) begin
        burst_en = 1'b0; wait_cyc(1 + int'($urandom % 1500));
      end else begin
        pwr_on = 1'b0; wait_cyc(1 + int'($urandom % 300));
        pwr_on = 1'b1; wait_cyc(1 + int'($urandom % 600));
      end
    end
    burst_en = 1'b0;
    wait_cyc(CLK_DIV * 12 + PIPE_LAT);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule